// File: doc/BRIEF.md
# Microprogram Sequencer with Writable Control Store

This block is the control unit of a small microprogrammed processor. A 64-entry control store holds 24-bit microwords. A micro-address register selects the current microword. A four-phase timing generator runs each microinstruction over phases T1 to T4. During those phases the microword is decoded into ALU function bits, a memory write strobe, register-load strobes and bus-source enables. The ALU, the registers and the memory are outside the block and take these strobes as their controls.

The next micro-address normally comes from a six-bit field in the current microword. A microword whose sequence-control field marks it as a dispatch point instead keeps the upper three bits of that field. It replaces the lower three bits with the opcode bits of the instruction register. This is how an instruction fetch branches to the routine for each instruction.

The timing generator can run continuously (start), run exactly one microinstruction (step), or finish the current microinstruction and halt (stop). A manual port writes or reads any control-store word at run time, so no preloaded memory image is needed. While that port is enabled, sequencing is suspended and every decoded output is held inactive.

Top module: `micro_seq`

## Requirements
- R1: After reset the micro-address is 0, the control store reads as all zeros, `phase_o` is 0 and every decoded output is 0. The block stays idle until start or step is asserted.
- R2: A start pulse while idle runs the phases T1, T2, T3, T4 on `phase_o` bits 0, 1, 2, 3, one phase per clock, with at most one bit set. The phases repeat until a stop pulse arrives. After a stop pulse, the current microinstruction finishes its T4 and the block then goes idle.
- R3: A step pulse while idle (start low) runs exactly one microinstruction, T1 to T4, and then the block returns to idle.
- R4: The micro-address changes only at the clock edge that ends T4. When the sequence-control field is not 001, the new micro-address is the next-address field.
- R5: When the sequence-control field is 001 (dispatch), the new micro-address is the upper three bits of the next-address field, followed by `ir_i[7:5]`. The other instruction-register bits have no effect.
- R6: The load strobes and the memory write strobe pulse only during T3. Destination 010 gives `ld_opnd_a_o`, 011 gives `ld_opnd_b_o` and 110 gives `ld_addr_o`; any other destination code gives none of them. `mem_we_o` follows the write-enable bit.
- R7: During all four active phases, source 001 asserts `drv_acc_o` and source 110 asserts `drv_pc_o`. Any other source code asserts neither.
- R8: During active phases, `alu_fn_o` carries {S3..S0, M, Cn} of the microword and `aux_sel_o` carries its two auxiliary bits. The value 100101 selects addition. Both outputs are 0 while the block is idle.
- R9: With `man_en_i` and `man_wr_i` high, `man_wdata_i` is written at `man_addr_i` on the clock edge. With `man_en_i` high and `man_wr_i` low, `man_rdata_o` shows the word at `man_addr_i` after the next edge.
- R10: While `man_en_i` is high, `phase_o` and all decoded outputs are 0 in that same cycle. The current microinstruction is abandoned without changing the micro-address, and the block remains idle afterwards until start or step.
- R11: The microword layout is as follows: bits [23:20] are S3..S0, [19] is M, [18] is Cn, [17] is write enable, [16:15] are the auxiliary bits, [14:12] are the destination, [11:9] are the source, [8:6] are sequence control, and [5:0] are the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin continuous execution when idle |
| step_i | input | 1 | Execute one microinstruction when idle |
| stop_i | input | 1 | Halt after the current microinstruction |
| ir_i | input | 8 | Instruction register; bits [7:5] form the opcode |
| man_en_i | input | 1 | Manual control-store access mode |
| man_wr_i | input | 1 | Manual write (1) or read (0) |
| man_addr_i | input | 6 | Manual access address |
| man_wdata_i | input | 24 | Manual write data |
| man_rdata_o | output | 24 | Manual read data, one cycle latency |
| phase_o | output | 4 | One-hot timing phase T1..T4, 0 when idle |
| upc_o | output | 6 | Micro-address register |
| alu_fn_o | output | 6 | ALU function {S3..S0, M, Cn} |
| aux_sel_o | output | 2 | Auxiliary select bits |
| mem_we_o | output | 1 | Memory write strobe (T3) |
| ld_opnd_a_o | output | 1 | First operand register load (T3) |
| ld_opnd_b_o | output | 1 | Second operand register load (T3) |
| ld_addr_o | output | 1 | Address register load (T3) |
| drv_acc_o | output | 1 | Accumulator drives the bus |
| drv_pc_o | output | 1 | Program counter drives the bus |

## Verification
The assertions assume that `ir_i` is stable at the edge that ends T4. They also assume that the manual port is the only way the microword under execution changes. The bench therefore changes the instruction register only while the block is idle, and it writes microcode only with `man_en_i` high. That write mode itself drives the sequencer idle, so microcode is never replaced during a microinstruction. Control pulses are held for exactly one cycle. Start is always given from idle, and stop is given during T2, so each pulse has a single defined effect.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UA_W    = 6;
  localparam int DEPTH   = 1 << UA_W;
  localparam int IR_W    = 8;
  localparam int OP_W    = 3;
  localparam int FN_W    = 6;
  localparam int WORD_W  = 24;

  localparam logic [2:0] DST_OPA      = 3'b010;
  localparam logic [2:0] DST_OPB      = 3'b011;
  localparam logic [2:0] DST_AR       = 3'b110;
  localparam logic [2:0] SRC_ACC      = 3'b001;
  localparam logic [2:0] SRC_PC       = 3'b110;
  localparam logic [2:0] SEQ_DISPATCH = 3'b001;

  typedef struct packed {
    logic [3:0]      alu_s;
    logic            alu_m;
    logic            alu_cn;
    logic            wr_en;
    logic [1:0]      aux;
    logic [2:0]      dst;
    logic [2:0]      src;
    logic [2:0]      seq;
    logic [UA_W-1:0] nxt;
  } uword_t;

  typedef enum logic [2:0] {PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4} phase_e;

  typedef struct packed {
    logic [FN_W-1:0] alu_fn;
    logic [1:0]      aux;
    logic            mem_we;
    logic            ld_a;
    logic            ld_b;
    logic            ld_ar;
    logic            drv_acc;
    logic            drv_pc;
  } ctl_t;

  function automatic logic [UA_W-1:0] next_upc(uword_t w, logic [OP_W-1:0] op);
    if (w.seq == SEQ_DISPATCH) return {w.nxt[UA_W-1:OP_W], op};
    return w.nxt;
  endfunction

  function automatic ctl_t decode_word(uword_t w, logic active, logic strobe);
    ctl_t c;
    c         = '0;
    if (active) begin
      c.alu_fn  = {w.alu_s, w.alu_m, w.alu_cn};
      c.aux     = w.aux;
      c.drv_acc = (w.src == SRC_ACC);
      c.drv_pc  = (w.src == SRC_PC);
      if (strobe) begin
        c.mem_we = w.wr_en;
        c.ld_a   = (w.dst == DST_OPA);
        c.ld_b   = (w.dst == DST_OPB);
        c.ld_ar  = (w.dst == DST_AR);
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/useq_timing.sv
module useq_timing
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold,
  input  logic   start,
  input  logic   step,
  input  logic   stop,
  output phase_e state
);
  logic cont_q;
  logic halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      state  <= PH_IDLE;
      cont_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      case (state)
        PH_IDLE: begin
          halt_q <= 1'b0;
          if (start) begin
            state  <= PH_T1;
            cont_q <= 1'b1;
          end else if (step) begin
            state  <= PH_T1;
            cont_q <= 1'b0;
          end
        end
        PH_T1: begin state <= PH_T2; if (stop) halt_q <= 1'b1; end
        PH_T2: begin state <= PH_T3; if (stop) halt_q <= 1'b1; end
        PH_T3: begin state <= PH_T4; if (stop) halt_q <= 1'b1; end
        PH_T4: begin
          if (cont_q && !halt_q && !stop) state <= PH_T1;
          else begin
            state  <= PH_IDLE;
            cont_q <= 1'b0;
            halt_q <= 1'b0;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_en,
  input  logic              man_wr,
  input  logic [UA_W-1:0]   man_addr,
  input  logic [WORD_W-1:0] man_wdata,
  output logic [WORD_W-1:0] man_rdata,
  input  logic [UA_W-1:0]   rd_addr,
  output uword_t            rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      man_rdata <= '0;
    end else if (man_en) begin
      if (man_wr) mem[man_addr] <= man_wdata;
      else        man_rdata     <= mem[man_addr];
    end
  end

  assign rd_word = uword_t'(mem[rd_addr]);
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  uword_t word,
  input  logic   active,
  input  logic   strobe,
  output ctl_t   ctl
);
  assign ctl = decode_word(word, active, strobe);
endmodule

// File: rtl/micro_seq.sv
module micro_seq
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              stop_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              man_en_i,
  input  logic              man_wr_i,
  input  logic [UA_W-1:0]   man_addr_i,
  input  logic [WORD_W-1:0] man_wdata_i,
  output logic [WORD_W-1:0] man_rdata_o,
  output logic [3:0]        phase_o,
  output logic [UA_W-1:0]   upc_o,
  output logic [FN_W-1:0]   alu_fn_o,
  output logic [1:0]        aux_sel_o,
  output logic              mem_we_o,
  output logic              ld_opnd_a_o,
  output logic              ld_opnd_b_o,
  output logic              ld_addr_o,
  output logic              drv_acc_o,
  output logic              drv_pc_o
);
  phase_e          state;
  uword_t          cur_word;
  ctl_t            ctl;
  logic            active;
  logic            t3_evt;
  logic            t4_evt;
  logic [UA_W-1:0] upc_q;
  logic [UA_W-1:0] upc_next;

  useq_timing u_timing (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (man_en_i),
    .start (start_i),
    .step  (step_i),
    .stop  (stop_i),
    .state (state)
  );

  useq_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .man_en    (man_en_i),
    .man_wr    (man_wr_i),
    .man_addr  (man_addr_i),
    .man_wdata (man_wdata_i),
    .man_rdata (man_rdata_o),
    .rd_addr   (upc_q),
    .rd_word   (cur_word)
  );

  // Named internal events, visible to the checker
  assign active = (state != PH_IDLE) && !man_en_i;
  assign t3_evt = active && (state == PH_T3);
  assign t4_evt = active && (state == PH_T4);

  useq_decode u_decode (
    .word   (cur_word),
    .active (active),
    .strobe (t3_evt),
    .ctl    (ctl)
  );

  assign upc_next = next_upc(cur_word, ir_i[IR_W-1 -: OP_W]);

  always_ff @(posedge clk) begin
    if (!rst_n)      upc_q <= '0;
    else if (t4_evt) upc_q <= upc_next;
  end

  always_comb begin
    phase_o = '0;
    if (active) begin
      case (state)
        PH_T1:   phase_o = 4'b0001;
        PH_T2:   phase_o = 4'b0010;
        PH_T3:   phase_o = 4'b0100;
        PH_T4:   phase_o = 4'b1000;
        default: phase_o = '0;
      endcase
    end
  end

  assign upc_o       = upc_q;
  assign alu_fn_o    = ctl.alu_fn;
  assign aux_sel_o   = ctl.aux;
  assign mem_we_o    = ctl.mem_we;
  assign ld_opnd_a_o = ctl.ld_a;
  assign ld_opnd_b_o = ctl.ld_b;
  assign ld_addr_o   = ctl.ld_ar;
  assign drv_acc_o   = ctl.drv_acc;
  assign drv_pc_o    = ctl.drv_pc;
endmodule

// File: rtl/micro_seq_chk.sv
module micro_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        man_en_i,
  input logic [7:0]  ir_i,
  input logic [23:0] word,
  input logic [3:0]  phase_o,
  input logic [5:0]  upc_o,
  input logic [5:0]  alu_fn_o,
  input logic [1:0]  aux_sel_o,
  input logic        mem_we_o,
  input logic        ld_opnd_a_o,
  input logic        ld_opnd_b_o,
  input logic        ld_addr_o,
  input logic        drv_acc_o,
  input logic        drv_pc_o
);
  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_o));
  // R2
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[0] |=> (phase_o[1] || man_en_i));
  // R2
  t2_to_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[1] |=> (phase_o[2] || man_en_i));
  // R2
  t3_to_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[2] |=> (phase_o[3] || man_en_i));
  // R4
  upc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o[3] |=> $stable(upc_o));
  // R5
  dispatch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o[3] && word[8:6] == 3'b001) |=> (upc_o[2:0] == $past(ir_i[7:5])));
  // R6
  strobe_in_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || ld_opnd_a_o || ld_opnd_b_o || ld_addr_o) |-> phase_o[2]);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 4'b0000) |-> (alu_fn_o == 6'd0 && aux_sel_o == 2'd0 && !drv_acc_o && !drv_pc_o));
  // R10
  manual_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_en_i |-> (phase_o == 4'b0000 && !mem_we_o && !ld_opnd_a_o && !ld_opnd_b_o && !ld_addr_o));
endmodule

bind micro_seq micro_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .man_en_i    (man_en_i),
  .ir_i        (ir_i),
  .word        (cur_word),
  .phase_o     (phase_o),
  .upc_o       (upc_o),
  .alu_fn_o    (alu_fn_o),
  .aux_sel_o   (aux_sel_o),
  .mem_we_o    (mem_we_o),
  .ld_opnd_a_o (ld_opnd_a_o),
  .ld_opnd_b_o (ld_opnd_b_o),
  .ld_addr_o   (ld_addr_o),
  .drv_acc_o   (drv_acc_o),
  .drv_pc_o    (drv_pc_o)
);

// File: tb/test_micro_seq.sv
module test_micro_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, step_i = 1'b0, stop_i = 1'b0;
  logic [7:0]  ir_i = '0;
  logic        man_en_i = 1'b0, man_wr_i = 1'b0;
  logic [5:0]  man_addr_i = '0;
  logic [23:0] man_wdata_i = '0;
  logic [23:0] man_rdata_o;
  logic [3:0]  phase_o;
  logic [5:0]  upc_o, alu_fn_o;
  logic [1:0]  aux_sel_o;
  logic        mem_we_o, ld_opnd_a_o, ld_opnd_b_o, ld_addr_o, drv_acc_o, drv_pc_o;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  micro_seq i_micro_seq (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R11: field layout of a microword
  function automatic logic [23:0] mk(logic [5:0] fn, logic we, logic [1:0] aux,
                                      logic [2:0] dst, logic [2:0] src,
                                      logic [2:0] seq, logic [5:0] nxt);
    return {fn, we, aux, dst, src, seq, nxt};
  endfunction

  // Expected output bundle {alu_fn, aux, we, lda, ldb, ldar, acc, pc} for phase p (1..4)
  function automatic logic [13:0] expect_ctl(logic [23:0] w, int p);
    logic [2:0] d, s;
    logic t3;
    d  = w[14:12];
    s  = w[11:9];
    t3 = (p == 3);
    return {w[23:18], w[16:15], t3 & w[17], t3 & (d == 3'd2), t3 & (d == 3'd3),
            t3 & (d == 3'd6), s == 3'd1, s == 3'd6};
  endfunction

  function automatic logic [13:0] got_ctl();
    return {alu_fn_o, aux_sel_o, mem_we_o, ld_opnd_a_o, ld_opnd_b_o, ld_addr_o,
            drv_acc_o, drv_pc_o};
  endfunction

  function automatic logic [23:0] pat(int a);
    logic [23:0] v;
    v = 24'(a) * 24'd40503 + 24'h13579B;
    return v ^ (24'(a) << 12);
  endfunction

  function automatic logic [23:0] sweep_word(int a);
    logic [5:0] b;
    b = 6'(a);
    return mk({b[3:0] ^ 4'h9, b[4], b[5]}, b[0] ^ b[3], b[2:1], b[2:0], b[5:3],
              3'b000, 6'(a + 1));
  endfunction

  task automatic mwrite(int a, logic [23:0] d);
    man_en_i = 1'b1; man_wr_i = 1'b1; man_addr_i = 6'(a); man_wdata_i = d;
    tick();
    man_en_i = 1'b0; man_wr_i = 1'b0;
  endtask

  task automatic do_step();
    step_i = 1'b1;
    tick();
    step_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state and idle hold
    chk("R1 phase", 32'(phase_o), 0);
    chk("R1 upc", 32'(upc_o), 0);
    chk("R1 ctl", 32'(got_ctl()), 0);
    repeat (3) tick();
    chk("R1 idle without start", 32'(phase_o), 0);
    man_en_i = 1'b1; man_addr_i = 6'd17;
    tick();
    man_en_i = 1'b0;
    chk("R1 store cleared", 32'(man_rdata_o), 0);

    // R9 write and read every address
    for (int a = 0; a < 64; a++) mwrite(a, pat(a));
    for (int a = 0; a < 64; a++) begin
      man_en_i = 1'b1; man_wr_i = 1'b0; man_addr_i = 6'(a);
      tick();
      chk("R9 readback", 32'(man_rdata_o), 32'(pat(a)));
    end
    man_en_i = 1'b0;

    // R2/R4/R6/R7/R8 continuous run over all destination and source codes
    for (int a = 0; a < 64; a++) mwrite(a, sweep_word(a));
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int a = 0; a < 64; a++) begin
      for (int p = 1; p <= 4; p++) begin
        chk("R2 phase", 32'(phase_o), 32'(4'b0001 << (p - 1)));
        chk("R4 upc", 32'(upc_o), 32'(a));
        chk("R6/R7/R8 ctl", 32'(got_ctl()), 32'(expect_ctl(sweep_word(a), p)));
        tick();
      end
    end
    // R2 stop during T2 of the word at 0
    chk("R2 wrapped", 32'(phase_o), 1);
    tick();
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    tick();
    chk("R2 stop finishes T4", 32'(phase_o), 32'h8);
    tick();
    chk("R2 idle after stop", 32'(phase_o), 0);
    chk("R2 upc after stop", 32'(upc_o), 1);
    tick();
    chk("R2 stays idle", 32'(phase_o), 0);

    // R3 single step
    do_step();
    chk("R3 step T1", 32'(phase_o), 1);
    repeat (3) tick();
    chk("R3 step T4", 32'(phase_o), 32'h8);
    tick();
    chk("R3 idle after step", 32'(phase_o), 0);
    chk("R3 upc advanced", 32'(upc_o), 2);

    // R10 manual mode during a run
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    tick();
    man_en_i = 1'b1; man_wr_i = 1'b0; man_addr_i = 6'd5;
    #1;
    chk("R10 phase forced", 32'(phase_o), 0);
    chk("R10 ctl forced", 32'(got_ctl()), 0);
    tick();
    chk("R10 suspended", 32'(phase_o), 0);
    chk("R10 upc held", 32'(upc_o), 2);
    chk("R9 read while suspended", 32'(man_rdata_o), 32'(sweep_word(5)));
    man_en_i = 1'b0;
    tick();
    chk("R10 idle after release", 32'(phase_o), 0);

    // R5 dispatch on opcode bits
    mwrite(2, mk(6'd0, 1'b0, 2'd0, 3'd0, 3'd0, 3'b000, 6'd0));
    mwrite(0, mk(6'd0, 1'b0, 2'd0, 3'd0, 3'd0, 3'b001, 6'b101_011));
    for (int k = 40; k < 48; k++) mwrite(k, mk(6'd0, 1'b0, 2'd0, 3'd0, 3'd0, 3'b000, 6'd0));
    do_step();
    repeat (4) tick();
    chk("R4 back to 0", 32'(upc_o), 0);
    for (int op = 0; op < 8; op++) begin
      ir_i = {3'(op), 5'(op * 7 + 3)};
      do_step();
      repeat (4) tick();
      chk("R5 dispatch target", 32'(upc_o), 32'(40 + op));
      do_step();
      repeat (4) tick();
      chk("R4 return", 32'(upc_o), 0);
    end

    // R8 add routine: fetch, two memory reads, operand load, add
    mwrite(0, mk(6'b000000, 1'b0, 2'd0, 3'd6, 3'd6, 3'd0, 6'd1));
    mwrite(1, mk(6'b000000, 1'b0, 2'd0, 3'd6, 3'd0, 3'd0, 6'd2));
    mwrite(2, mk(6'b000000, 1'b0, 2'd0, 3'd3, 3'd0, 3'd0, 6'd3));
    mwrite(3, mk(6'b000000, 1'b0, 2'd0, 3'd2, 3'd1, 3'd0, 6'd4));
    mwrite(4, mk(6'b100101, 1'b1, 2'd2, 3'd1, 3'd0, 3'd0, 6'd0));
    for (int i = 0; i < 5; i++) begin
      logic [23:0] w;
      case (i)
        0: w = mk(6'b000000, 1'b0, 2'd0, 3'd6, 3'd6, 3'd0, 6'd1);
        1: w = mk(6'b000000, 1'b0, 2'd0, 3'd6, 3'd0, 3'd0, 6'd2);
        2: w = mk(6'b000000, 1'b0, 2'd0, 3'd3, 3'd0, 3'd0, 6'd3);
        3: w = mk(6'b000000, 1'b0, 2'd0, 3'd2, 3'd1, 3'd0, 6'd4);
        default: w = mk(6'b100101, 1'b1, 2'd2, 3'd1, 3'd0, 3'd0, 6'd0);
      endcase
      do_step();
      tick();
      tick();
      chk("R8 add routine T3", 32'(got_ctl()), 32'(expect_ctl(w, 3)));
      tick();
      tick();
      chk("R4 add routine upc", 32'(upc_o), 32'((i + 1) % 5));
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule